// File: doc/BRIEF.md
# Microsecond Interval Timer with Read-Acknowledged Limit

This block holds a set of interval timers behind one word-addressed register port. There is one timer per processor and one shared system timer. Each timer counts ticks of an external one-microsecond enable pulse. When its count reaches a value programmed by software, it raises a level interrupt and starts its count again. The system timer drives the level-10 request line, and each processor timer drives that processor's level-14 request line.

Software acknowledges an interrupt by reading the timer's limit word. The read returns the pending flag in bit 31 and clears the flag. A second write address loads a new limit without disturbing a pending interrupt or the running count. Limit and count values are left-aligned: the value field occupies bits 30..10, so a period of P microseconds is programmed by writing (P+1) << 10. Writing a zero limit makes a processor timer stop producing ticks.

Top module: `usec_limit_timer`

## Requirements
- R1: Byte address bits [ADDR_W-1:5] select the timer: indices 0..NUM_CPU-1 are the processor timers and index NUM_CPU is the system timer. Address bits [4:2] select the word: 0 = limit, 1 = count, 2 = limit without acknowledge, 3 = reserved, 4 = configuration (system timer only). Address bits [1:0] are ignored.
- R2: Limit and count values occupy bits 30..10 of their words. Bits 9..0 always read zero. Bit 31 of a written limit is ignored, and bit 31 of a count read is zero.
- R3: In every cycle with usec_tick high, the count rises by one. When the limit L is nonzero and the count equals L-1, that tick instead sets the count to 1 and sets the timer's flag, so the flag sets once every L-1 ticks.
- R4: A read of word 0 returns the flag in bit 31 and the limit in bits 30..10, and it clears the flag at the end of that cycle. If a tick sets the flag in the same cycle, the flag stays set.
- R5: A write to word 0 loads the limit from bits 30..10, sets the count to 1 and clears the flag.
- R6: A write to word 2 loads the limit and leaves the flag and the count unchanged. A read of word 2 returns the same data as word 0 but does not clear the flag.
- R7: While a timer's limit is zero, its flag is never set, and its count wraps modulo 2^21.
- R8: irq_sys equals the system timer's flag, and irq_cpu[i] equals processor timer i's flag.
- R9: A write to word 4 of the system timer stores bits [NUM_CPU-1:0], and a read of that word returns them zero-extended. Word 4 of a processor timer reads zero.
- R10: Writes to the count word, to the reserved word, to words 5..7 and to unmapped timer indices have no effect. Reads of the reserved word, of words 5..7 and of unmapped indices return zero.
- R11: After reset, every count is 1, every limit is 0, every flag is 0 and the configuration is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usec_tick | input | 1 | One-cycle pulse per microsecond |
| bus_en | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address: timer index above bit 5, word in [4:2] |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| irq_sys | output | 1 | Level-10 request from the system timer |
| irq_cpu | output | NUM_CPU | Level-14 request per processor timer |

## Verification
Directed sequences program short periods and count ticks to the exact cycle in which the flag sets. This separates an off-by-one in the wrap compare from a correct period. A read issued in the same cycle as a wrapping tick tells whether set or clear has priority. Acknowledge-by-read is compared against the no-acknowledge alias to show that only word 0 clears the flag. Long runs of random accesses then exercise every timer index, including unmapped ones, every word, and random tick density. Each read and every interrupt line is compared against a bench model, which catches cross-talk between timers and stray decode hits.

// File: rtl/timer_pkg.sv
// Shared word indices for the interval timer register port.
// Assumes a 32-byte window per timer, addressed by 32-bit words.
package timer_pkg;
    localparam int OFF_W = 5;

    typedef logic [2:0] word_t;

    localparam word_t WORD_LIMIT  = 3'd0;
    localparam word_t WORD_COUNT  = 3'd1;
    localparam word_t WORD_KEEP   = 3'd2;
    localparam word_t WORD_RSVD   = 3'd3;
    localparam word_t WORD_CONFIG = 3'd4;
endpackage

// File: rtl/timer_core.sv
// One interval timer: a count, a limit and a sticky flag.
// The count advances on each tick. When the limit is nonzero and the count
// equals limit-1, the tick reloads the count to 1 and sets the flag.
// Assumes the register decoder asserts at most one strobe per cycle.
module timer_core #(
    parameter int VAL_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic             keep_wr,
    input  logic             ack_rd,
    input  logic [VAL_W-1:0] new_limit,
    output logic [VAL_W-1:0] count,
    output logic [VAL_W-1:0] limit,
    output logic             flag
);
    logic wrap;

    // Terminal detect against the limit currently held.
    assign wrap = (limit != '0) && (count == limit - VAL_W'(1));

    // Count and limit storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= VAL_W'(1);
            limit <= '0;
        end else if (load_wr) begin
            limit <= new_limit;
            count <= VAL_W'(1);
        end else begin
            if (keep_wr) limit <= new_limit;
            if (tick)    count <= wrap ? VAL_W'(1) : count + VAL_W'(1);
        end
    end

    // Sticky flag: a load clears it, a wrap sets it, an acknowledge clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)             flag <= 1'b0;
        else if (load_wr)       flag <= 1'b0;
        else if (tick && wrap)  flag <= 1'b1;
        else if (ack_rd)        flag <= 1'b0;
    end

    a_r5_load_resets: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (!flag && count == VAL_W'(1)));
    a_r6_keep_holds_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_wr && flag) |=> flag);
    a_r7_zero_limit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (limit == '0) |=> !$rose(flag));
    a_r3_flag_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick));
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd && !tick) |=> !flag);
endmodule

// File: rtl/timer_regs.sv
// Register decoder for the timer array.
// It turns a single-cycle access into per-timer strobes, holds the
// configuration word and builds the combinational read data.
// Assumes timer indices at or above NUM_CPU+1 are unmapped.
module timer_regs #(
    parameter int NUM_CPU   = 4,
    parameter int DATA_W    = 32,
    parameter int FRAC_BITS = 10,
    localparam int NINST    = NUM_CPU + 1,
    localparam int INST_W   = $clog2(NINST),
    localparam int ADDR_W   = INST_W + timer_pkg::OFF_W,
    localparam int VAL_W    = DATA_W - FRAC_BITS - 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_en,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    input  logic [NINST-1:0]            inst_flag,
    input  logic [NINST-1:0][VAL_W-1:0] inst_limit,
    input  logic [NINST-1:0][VAL_W-1:0] inst_count,
    output logic [NINST-1:0]            load_wr,
    output logic [NINST-1:0]            keep_wr,
    output logic [NINST-1:0]            ack_rd,
    output logic [VAL_W-1:0]            new_limit,
    output logic [DATA_W-1:0]           bus_rdata
);
    import timer_pkg::*;

    logic [INST_W-1:0]  inst_idx;
    logic [INST_W-1:0]  inst_safe;
    word_t              word_sel;
    logic               in_range;
    logic               is_sys;
    logic               cfg_wr;
    logic [NUM_CPU-1:0] cfg_q;

    assign inst_idx  = bus_addr[ADDR_W-1:OFF_W];
    assign word_sel  = bus_addr[OFF_W-1:2];
    assign in_range  = {1'b0, inst_idx} < (INST_W+1)'(NINST);
    assign inst_safe = in_range ? inst_idx : '0;
    assign is_sys    = inst_idx == INST_W'(NUM_CPU);
    assign new_limit = bus_wdata[DATA_W-2:FRAC_BITS];
    assign cfg_wr    = bus_en && bus_wr && is_sys && (word_sel == WORD_CONFIG);

    // Per-timer access strobes.
    for (genvar g = 0; g < NINST; g++) begin : g_strobe
        logic hit;
        assign hit        = bus_en && (inst_idx == INST_W'(g));
        assign load_wr[g] = hit &&  bus_wr && (word_sel == WORD_LIMIT);
        assign keep_wr[g] = hit &&  bus_wr && (word_sel == WORD_KEEP);
        assign ack_rd[g]  = hit && !bus_wr && (word_sel == WORD_LIMIT);
    end

    // Configuration word of the system timer.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_wr) cfg_q <= bus_wdata[NUM_CPU-1:0];
    end

    // Read data for the addressed word.
    always_comb begin
        bus_rdata = '0;
        if (bus_en && !bus_wr && in_range) begin
            case (word_sel)
                WORD_LIMIT, WORD_KEEP:
                    bus_rdata = {inst_flag[inst_safe], inst_limit[inst_safe], {FRAC_BITS{1'b0}}};
                WORD_COUNT:
                    bus_rdata = {1'b0, inst_count[inst_safe], {FRAC_BITS{1'b0}}};
                WORD_CONFIG:
                    if (is_sys) bus_rdata = DATA_W'(cfg_q);
                default:
                    bus_rdata = '0;
            endcase
        end
    end

    a_r9_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(cfg_q));
    a_r9_cfg_loads: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_q == $past(bus_wdata[NUM_CPU-1:0])));
    a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !in_range) |-> (load_wr == '0 && keep_wr == '0 && ack_rd == '0 && bus_rdata == '0));
endmodule

// File: rtl/usec_limit_timer.sv
// Top of the interval timer array: NUM_CPU processor timers plus one system
// timer, all advanced by a shared one-microsecond tick.
// Assumes usec_tick is synchronous to clk and one cycle wide.
module usec_limit_timer #(
    parameter int NUM_CPU   = 4,
    parameter int DATA_W    = 32,
    parameter int FRAC_BITS = 10,
    localparam int NINST    = NUM_CPU + 1,
    localparam int INST_W   = $clog2(NINST),
    localparam int ADDR_W   = INST_W + timer_pkg::OFF_W,
    localparam int VAL_W    = DATA_W - FRAC_BITS - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               usec_tick,
    input  logic               bus_en,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_sys,
    output logic [NUM_CPU-1:0] irq_cpu
);
    logic [NINST-1:0]            flags;
    logic [NINST-1:0][VAL_W-1:0] limits;
    logic [NINST-1:0][VAL_W-1:0] counts;
    logic [NINST-1:0]            load_wr;
    logic [NINST-1:0]            keep_wr;
    logic [NINST-1:0]            ack_rd;
    logic [VAL_W-1:0]            new_limit;

    timer_regs #(
        .NUM_CPU   (NUM_CPU),
        .DATA_W    (DATA_W),
        .FRAC_BITS (FRAC_BITS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_en     (bus_en),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .inst_flag  (flags),
        .inst_limit (limits),
        .inst_count (counts),
        .load_wr    (load_wr),
        .keep_wr    (keep_wr),
        .ack_rd     (ack_rd),
        .new_limit  (new_limit),
        .bus_rdata  (bus_rdata)
    );

    // One timer core per processor plus the system timer.
    for (genvar g = 0; g < NINST; g++) begin : g_timer
        timer_core #(.VAL_W(VAL_W)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (usec_tick),
            .load_wr   (load_wr[g]),
            .keep_wr   (keep_wr[g]),
            .ack_rd    (ack_rd[g]),
            .new_limit (new_limit),
            .count     (counts[g]),
            .limit     (limits[g]),
            .flag      (flags[g])
        );
    end

    assign irq_cpu = flags[NUM_CPU-1:0];
    assign irq_sys = flags[NUM_CPU];
endmodule

// File: tb/usec_limit_timer_bench.sv
module usec_limit_timer_bench;
    localparam int NUM_CPU = 4;
    localparam int NINST   = NUM_CPU + 1;
    localparam int INST_W  = $clog2(NINST);
    localparam int ADDR_W  = INST_W + 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              usec_tick = 1'b0;
    logic              bus_en = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_sys;
    logic [NUM_CPU-1:0] irq_cpu;

    int checks = 0;
    int fails  = 0;

    logic [20:0]        m_cnt [NINST];
    logic [20:0]        m_lim [NINST];
    logic               m_flg [NINST];
    logic [NUM_CPU-1:0] m_cfg;

    always #10 clk = ~clk;

    usec_limit_timer u_usec_limit_timer (
        .clk(clk), .rst_n(rst_n), .usec_tick(usec_tick), .bus_en(bus_en),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_sys(irq_sys), .irq_cpu(irq_cpu)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected read data from the bench model (R1, R2, R4, R6, R9, R10).
    function automatic logic [31:0] exp_read(input logic [ADDR_W-1:0] a);
        int inst = int'(a[ADDR_W-1:5]);
        int word = int'(a[4:2]);
        if (inst >= NINST) return 32'h0;
        case (word)
            0, 2: return {m_flg[inst], m_lim[inst], 10'h0};
            1:    return {1'b0, m_cnt[inst], 10'h0};
            4:    return (inst == NUM_CPU) ? 32'(m_cfg) : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    // Advance the model by one clock edge (R3 to R7, R9, R10).
    task automatic model_step(input logic en, input logic wr, input logic [ADDR_W-1:0] a,
                              input logic [31:0] d, input logic tk);
        int inst = int'(a[ADDR_W-1:5]);
        int word = int'(a[4:2]);
        for (int i = 0; i < NINST; i++) begin
            logic ld  = en && wr && inst == i && word == 0;
            logic kp  = en && wr && inst == i && word == 2;
            logic ack = en && !wr && inst == i && word == 0;
            logic hit = tk && m_lim[i] != 21'd0 && m_cnt[i] == 21'(m_lim[i] - 21'd1);
            if (ld) begin
                m_lim[i] = d[30:10];
                m_cnt[i] = 21'd1;
                m_flg[i] = 1'b0;
            end else begin
                if (tk) m_cnt[i] = hit ? 21'd1 : 21'(m_cnt[i] + 21'd1);
                if (hit) m_flg[i] = 1'b1;
                else if (ack) m_flg[i] = 1'b0;
                if (kp) m_lim[i] = d[30:10];
            end
        end
        if (en && wr && inst == NUM_CPU && word == 4) m_cfg = d[NUM_CPU-1:0];
    endtask

    // One bus cycle, entered and left at a falling edge.
    task automatic cyc(input logic en, input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [31:0] d, input logic tk, output logic [31:0] got);
        logic [31:0] ex_irq = '0;
        bus_en = en; bus_wr = wr; bus_addr = a; bus_wdata = d; usec_tick = tk;
        #1;
        got = bus_rdata;
        for (int i = 0; i < NINST; i++) ex_irq[i] = m_flg[i];
        chk("R8 irq lines", {27'h0, irq_sys, irq_cpu}, ex_irq);
        if (en && !wr) begin
            case (int'(a[4:2]))
                0: chk("R4 limit read", got, exp_read(a));
                1: chk("R3 count read", got, exp_read(a));
                2: chk("R6 keep read", got, exp_read(a));
                4: chk("R9 config read", got, exp_read(a));
                default: chk("R10 reserved read", got, exp_read(a));
            endcase
        end
        model_step(en, wr, a, d, tk);
        @(posedge clk);
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; usec_tick = 1'b0;
    endtask

    function automatic logic [ADDR_W-1:0] adr(input int inst, input int word);
        return {INST_W'(inst), 3'(word), 2'b00};
    endfunction

    task automatic wr(input int inst, input int word, input logic [31:0] d);
        logic [31:0] g;
        cyc(1'b1, 1'b1, adr(inst, word), d, 1'b0, g);
    endtask

    task automatic rd(input int inst, input int word, input string req, input logic [31:0] exp);
        logic [31:0] g;
        cyc(1'b1, 1'b0, adr(inst, word), 32'h0, 1'b0, g);
        chk(req, g, exp);
    endtask

    task automatic idle(input logic tk, input int n);
        logic [31:0] g;
        for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, '0, 32'h0, tk, g);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] g;
        for (int i = 0; i < NINST; i++) begin
            m_cnt[i] = 21'd1; m_lim[i] = '0; m_flg[i] = 1'b0;
        end
        m_cfg = '0;
        void'($urandom(32'h1B2C3D4E));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(0, 1, "R11 reset count", 32'h0000_0400);
        rd(0, 0, "R11 reset limit", 32'h0);
        rd(NUM_CPU, 4, "R11 reset config", 32'h0);
        chk("R11 reset irq", {27'h0, irq_sys, irq_cpu}, 32'h0);

        // R3/R5 period 5 on processor 0
        wr(0, 0, 32'h0000_1800);
        idle(1'b1, 4);
        chk("R3 no flag before period", 32'(irq_cpu[0]), 32'h0);
        idle(1'b1, 1);
        chk("R3 flag at period", 32'(irq_cpu[0]), 32'h1);
        rd(0, 1, "R3 count reloaded to 1", 32'h0000_0400);
        rd(0, 0, "R4 read shows flag", 32'h8000_1800);
        chk("R4 read acknowledges", 32'(irq_cpu[0]), 32'h0);

        // R6 keep alias
        idle(1'b1, 5);
        wr(0, 2, 32'h0000_2000);
        chk("R6 keep write holds irq", 32'(irq_cpu[0]), 32'h1);
        rd(0, 1, "R6 keep write holds count", 32'h0000_0400);
        rd(0, 2, "R6 keep read", 32'h8000_2000);
        chk("R6 keep read no ack", 32'(irq_cpu[0]), 32'h1);
        rd(0, 0, "R4 ack after keep", 32'h8000_2000);

        // R7 zero limit
        wr(1, 0, 32'h0);
        idle(1'b1, 100);
        chk("R7 zero limit quiet", 32'(irq_cpu[1]), 32'h0);
        rd(1, 1, "R7 free count", 32'h0001_9400);

        // R4 set wins over acknowledge in the same cycle
        wr(2, 0, 32'h0000_0C00);
        idle(1'b1, 1);
        cyc(1'b1, 1'b0, adr(2, 0), 32'h0, 1'b1, g);
        chk("R4 read before set", g, 32'h0000_0C00);
        chk("R4 set beats ack", 32'(irq_cpu[2]), 32'h1);

        // R10 ignored writes and reserved reads
        wr(2, 1, 32'hFFFF_FFFF);
        rd(2, 1, "R10 count write ignored", 32'h0000_0400);
        wr(2, 3, 32'hFFFF_FFFF);
        rd(2, 3, "R10 reserved reads zero", 32'h0);
        wr(2, 6, 32'hFFFF_FFFF);
        rd(2, 0, "R10 flag untouched", 32'h8000_0C00);
        wr(6, 0, 32'h0123_4400);
        rd(6, 0, "R1 unmapped reads zero", 32'h0);

        // R2 field alignment
        wr(3, 0, 32'h8000_37FF);
        rd(3, 0, "R2 field alignment", 32'h0000_3400);

        // R8/R9 system timer
        wr(NUM_CPU, 0, 32'h0000_0C00);
        idle(1'b1, 1);
        chk("R8 irq_sys low", 32'(irq_sys), 32'h0);
        idle(1'b1, 1);
        chk("R8 irq_sys high", 32'(irq_sys), 32'h1);
        wr(NUM_CPU, 4, 32'hFFFF_FFFA);
        rd(NUM_CPU, 4, "R9 config readback", 32'h0000_000A);
        rd(0, 4, "R9 processor word 4 zero", 32'h0);

        // Random traffic checked against the model
        for (int n = 0; n < 4000; n++) begin
            logic        en = ($urandom % 3) != 0;
            logic        w  = $urandom % 2;
            int          inst = $urandom % (NINST + 2);
            int          word = ($urandom % 4 == 0) ? ($urandom % 8) : ($urandom % 3);
            logic [31:0] d;
            logic [ADDR_W-1:0] a;
            if ($urandom % 8 == 0) d = $urandom;
            else d = {1'($urandom), 21'(($urandom % 12) + 2), 10'($urandom)};
            a = {INST_W'(inst), 3'(word), 2'($urandom)};
            cyc(en, w, a, d, 1'($urandom), g);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule